// File: doc/BRIEF.md
# Integer Register Rename Map

This block translates architectural integer register numbers into physical tags for an out-of-order core. The core has 32 architectural registers and a 48-entry physical space. Tags 0 to 31 are the committed homes of the architectural registers after reset. Tags 32 to 47 form the pool that the block hands out for speculative results. Each cycle a group of up to four instructions is presented. Every instruction carries two source register numbers and, optionally, one destination register number. In the same cycle the block returns a physical tag for every source and a fresh tag for every destination. A source that names a register written by an earlier instruction in the same group receives that earlier instruction's new tag.

When the pool cannot supply every destination in the group, the block raises a stall and the whole group is held back. The front end keeps the group on the inputs until the stall drops. Up to four instructions retire per cycle, in program order. Each retiring instruction moves its register's committed mapping to its own tag, and the tag it replaces goes back to the pool. A flush discards all speculation. It restores the speculative map from the committed map and rebuilds the pool from every tag that the committed map does not use.

Top module: `rename_map`

## Requirements
- R1: After a synchronous active-low reset, both the speculative and the committed map send architectural register r to tag r, and tags 32 to 47 are free.
- R2: Slot i of a group uses bits [5i+4:5i] of each register-number bus and bits [6i+5:6i] of each tag bus. With no same-group writer, a source tag equals the speculative mapping of that source register.
- R3: A source in slot i that names the destination of a valid, destination-carrying slot j<i receives the new tag of the nearest such j.
- R4: Destination tags are taken from the free pool, lowest number first, in ascending slot order. Slots that are invalid or have no destination allocate nothing and show destination tag 0.
- R5: When the number of destinations in a group exceeds the number of free tags, rn_stall is 1 and the group changes neither map nor pool.
- R6: An accepted group updates the speculative map for each destination, and the highest slot wins when several slots name the same register.
- R7: Retiring slot j sets the committed mapping of ret_dst[j] to ret_tag[j] and frees the tag it replaces. Retiring slots apply in ascending order, so a later slot naming the same register frees the earlier slot's tag.
- R8: A flush loads the committed map into the speculative map, with retirements of the same cycle included. It makes exactly the tags not used by the committed map free, which is always 16 of them. A group presented in the flush cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rn_valid | input | 4 | Per-slot valid for the rename group |
| rn_has_dst | input | 4 | Per-slot flag: instruction writes a destination |
| rn_src_a | input | 20 | First source register number per slot |
| rn_src_b | input | 20 | Second source register number per slot |
| rn_dst | input | 20 | Destination register number per slot |
| ret_valid | input | 4 | Per-slot retire of a destination-writing instruction |
| ret_dst | input | 20 | Destination register number of each retiring slot |
| ret_tag | input | 24 | Tag allocated to each retiring slot |
| flush | input | 1 | Discard speculation and restore the committed map |
| rn_stall | output | 1 | Group needs more tags than are free |
| rn_src_a_tag | output | 24 | Physical tag of each first source |
| rn_src_b_tag | output | 24 | Physical tag of each second source |
| rn_dst_tag | output | 24 | Newly allocated tag per slot, 0 if none |

## Verification
The hardest state to reach is a pool that is empty, or nearly empty, at the same moment that tags released by retirement have not yet come back. The stall decision and the lowest-first pick order then both depend on released tags arriving in the gaps below the rename range. The vector table builds this state on purpose. It renames four destinations per cycle while retiring older groups, so that committed tags 1, 2 and 3 return to the pool in between. It then drains the pool to zero, asks for one more tag, and flushes with a stalled group on the inputs. Directed tests then drive the partial-pool stall, and a same-register retire pair that lands in the flush cycle.

// File: rtl/rn_pkg.sv
// Package: sizes and shared types of the integer rename map.
// Assumes the committed homes of the architectural registers occupy the
// lowest tags and the rename pool sits directly above them.
package rn_pkg;
    localparam int unsigned ARCH_REGS    = 32;
    localparam int unsigned RENAME_SLOTS = 16;
    localparam int unsigned GROUP_W      = 4;
    localparam int unsigned PHYS_REGS    = ARCH_REGS + RENAME_SLOTS;
    localparam int unsigned AW           = $clog2(ARCH_REGS);
    localparam int unsigned TW           = $clog2(PHYS_REGS);
    localparam int unsigned CW           = $clog2(PHYS_REGS + 1);
    localparam int unsigned GW           = $clog2(GROUP_W + 1);

    typedef logic [AW-1:0] arch_t;
    typedef logic [TW-1:0] tag_t;
endpackage

// File: rtl/rn_free_pool.sv
// Module: free tag pool kept as one bit per physical tag.
// Picks the lowest free tags for the destination slots in slot order and
// flags a shortage when the pool cannot cover the whole group.
// Assumes release_vec never names a tag that is currently free.
module rn_free_pool
    import rn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GROUP_W-1:0]   alloc_req,
    input  logic                 fire,
    input  logic                 flush,
    input  logic [PHYS_REGS-1:0] release_vec,
    input  logic [PHYS_REGS-1:0] refill_vec,
    output tag_t                 grant [GROUP_W],
    output logic                 short_o,
    output logic [PHYS_REGS-1:0] free_q
);
    tag_t                 pick  [GROUP_W];
    logic [GW-1:0]        rank  [GROUP_W];
    logic [GW-1:0]        need;
    logic [CW-1:0]        avail;
    logic [PHYS_REGS-1:0] alloc_vec;

    // Find the k-th lowest free tag for every k in the group.
    always_comb begin : find_picks
        logic [CW-1:0] seen;
        seen = '0;
        for (int k = 0; k < GROUP_W; k++) pick[k] = '0;
        for (int p = 0; p < PHYS_REGS; p++) begin
            if (free_q[p]) begin
                for (int k = 0; k < GROUP_W; k++) begin
                    if (seen == CW'(k)) pick[k] = tag_t'(p);
                end
                seen = seen + 1'b1;
            end
        end
    end

    // Rank each requesting slot among the requesters before it.
    always_comb begin : rank_slots
        logic [GW-1:0] run;
        run = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            rank[i] = run;
            if (alloc_req[i]) run = run + 1'b1;
        end
        need = run;
    end

    // Hand out tags to requesting slots, zero elsewhere.
    always_comb begin : give_tags
        for (int i = 0; i < GROUP_W; i++) begin
            grant[i] = alloc_req[i] ? pick[rank[i]] : '0;
        end
    end

    // Compare demand with the number of free tags.
    always_comb begin : count_free
        avail   = CW'($countones(free_q));
        short_o = CW'(need) > avail;
    end

    // Collect the tags taken by an accepted group.
    always_comb begin : taken_tags
        alloc_vec = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            if (fire && alloc_req[i]) alloc_vec[grant[i]] = 1'b1;
        end
    end

    // Pool state: reset, flush rebuild, or take-and-release.
    always_ff @(posedge clk) begin : pool_reg
        if (!rst_n) begin
            for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p >= ARCH_REGS);
        end else if (flush) begin
            free_q <= refill_vec;
        end else begin
            free_q <= (free_q & ~alloc_vec) | release_vec;
        end
    end
endmodule

// File: rtl/rn_commit_map.sv
// Module: committed architectural-to-physical map.
// Applies up to GROUP_W in-order retirements per cycle, reports the tags
// they supersede, and derives the set of tags the committed map leaves free.
// Assumes retiring slots are presented in program order.
module rn_commit_map
    import rn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GROUP_W-1:0]   ret_valid,
    input  arch_t                ret_dst [GROUP_W],
    input  tag_t                 ret_tag [GROUP_W],
    output tag_t                 cmap_nxt [ARCH_REGS],
    output logic [PHYS_REGS-1:0] release_vec,
    output logic [PHYS_REGS-1:0] refill_vec
);
    tag_t                 cmap_q [ARCH_REGS];
    logic [PHYS_REGS-1:0] used_vec;

    // Walk retirements in slot order, chaining same-register updates.
    always_comb begin : retire_chain
        for (int r = 0; r < ARCH_REGS; r++) cmap_nxt[r] = cmap_q[r];
        release_vec = '0;
        for (int j = 0; j < GROUP_W; j++) begin
            if (ret_valid[j]) begin
                release_vec[cmap_nxt[ret_dst[j]]] = 1'b1;
                cmap_nxt[ret_dst[j]]              = ret_tag[j];
            end
        end
    end

    // Tags not held by the committed map form the refill set.
    always_comb begin : refill_set
        used_vec = '0;
        for (int r = 0; r < ARCH_REGS; r++) used_vec[cmap_nxt[r]] = 1'b1;
        refill_vec = ~used_vec;
    end

    // Committed map register, identity after reset.
    always_ff @(posedge clk) begin : cmap_reg
        if (!rst_n) begin
            for (int r = 0; r < ARCH_REGS; r++) cmap_q[r] <= tag_t'(r);
        end else begin
            for (int r = 0; r < ARCH_REGS; r++) cmap_q[r] <= cmap_nxt[r];
        end
    end
endmodule

// File: rtl/rn_spec_map.sv
// Module: speculative map with same-group dependency resolution.
// Looks up both sources of every slot, overriding with the newest earlier
// writer in the group, and records accepted destinations.
// Assumes grant holds valid tags whenever fire is high.
module rn_spec_map
    import rn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  arch_t              src_a [GROUP_W],
    input  arch_t              src_b [GROUP_W],
    input  arch_t              dst   [GROUP_W],
    input  logic [GROUP_W-1:0] wr_en,
    input  tag_t               grant [GROUP_W],
    input  logic               fire,
    input  logic               flush,
    input  tag_t               cmap_nxt [ARCH_REGS],
    output tag_t               src_a_tag [GROUP_W],
    output tag_t               src_b_tag [GROUP_W]
);
    tag_t smap_q [ARCH_REGS];

    // Source lookup with forwarding from earlier slots of the group.
    always_comb begin : lookup
        for (int i = 0; i < GROUP_W; i++) begin
            src_a_tag[i] = smap_q[src_a[i]];
            src_b_tag[i] = smap_q[src_b[i]];
            for (int j = 0; j < GROUP_W; j++) begin
                if (j < i && wr_en[j] && dst[j] == src_a[i]) src_a_tag[i] = grant[j];
                if (j < i && wr_en[j] && dst[j] == src_b[i]) src_b_tag[i] = grant[j];
            end
        end
    end

    // Speculative map: reset, restore on flush, or record a group.
    always_ff @(posedge clk) begin : smap_reg
        if (!rst_n) begin
            for (int r = 0; r < ARCH_REGS; r++) smap_q[r] <= tag_t'(r);
        end else if (flush) begin
            for (int r = 0; r < ARCH_REGS; r++) smap_q[r] <= cmap_nxt[r];
        end else if (fire) begin
            for (int i = 0; i < GROUP_W; i++) begin
                if (wr_en[i]) smap_q[dst[i]] <= grant[i];
            end
        end
    end
endmodule

// File: rtl/rename_map.sv
// Module: top of the integer rename map.
// Splits the flat slot buses, joins pool, speculative map and committed map,
// and decides whether the presented group is accepted this cycle.
// Assumes a stalled group is held on the inputs by the front end.
module rename_map
    import rn_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GROUP_W-1:0]      rn_valid,
    input  logic [GROUP_W-1:0]      rn_has_dst,
    input  logic [GROUP_W*AW-1:0]   rn_src_a,
    input  logic [GROUP_W*AW-1:0]   rn_src_b,
    input  logic [GROUP_W*AW-1:0]   rn_dst,
    input  logic [GROUP_W-1:0]      ret_valid,
    input  logic [GROUP_W*AW-1:0]   ret_dst,
    input  logic [GROUP_W*TW-1:0]   ret_tag,
    input  logic                    flush,
    output logic                    rn_stall,
    output logic [GROUP_W*TW-1:0]   rn_src_a_tag,
    output logic [GROUP_W*TW-1:0]   rn_src_b_tag,
    output logic [GROUP_W*TW-1:0]   rn_dst_tag
);
    arch_t                sa   [GROUP_W];
    arch_t                sb   [GROUP_W];
    arch_t                dd   [GROUP_W];
    arch_t                rd   [GROUP_W];
    tag_t                 rt   [GROUP_W];
    tag_t                 ta   [GROUP_W];
    tag_t                 tb   [GROUP_W];
    tag_t                 grant [GROUP_W];
    tag_t                 cmap_nxt [ARCH_REGS];
    logic [PHYS_REGS-1:0] release_vec;
    logic [PHYS_REGS-1:0] refill_vec;
    logic [PHYS_REGS-1:0] free_q;
    logic [GROUP_W-1:0]   alloc_req;
    logic                 short_w;
    logic                 fire;

    // Per-slot unpacking and packing of the flat buses.
    for (genvar i = 0; i < GROUP_W; i++) begin : g_slot
        assign sa[i] = rn_src_a[i*AW +: AW];
        assign sb[i] = rn_src_b[i*AW +: AW];
        assign dd[i] = rn_dst[i*AW +: AW];
        assign rd[i] = ret_dst[i*AW +: AW];
        assign rt[i] = ret_tag[i*TW +: TW];
        assign rn_src_a_tag[i*TW +: TW] = ta[i];
        assign rn_src_b_tag[i*TW +: TW] = tb[i];
        assign rn_dst_tag[i*TW +: TW]   = grant[i];
    end

    // Group acceptance: something valid, enough tags, no flush.
    always_comb begin : accept
        alloc_req = rn_valid & rn_has_dst;
        rn_stall  = short_w;
        fire      = (|rn_valid) && !short_w && !flush;
    end

    rn_free_pool u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .fire        (fire),
        .flush       (flush),
        .release_vec (release_vec),
        .refill_vec  (refill_vec),
        .grant       (grant),
        .short_o     (short_w),
        .free_q      (free_q)
    );

    rn_spec_map u_spec (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (sa),
        .src_b     (sb),
        .dst       (dd),
        .wr_en     (alloc_req),
        .grant     (grant),
        .fire      (fire),
        .flush     (flush),
        .cmap_nxt  (cmap_nxt),
        .src_a_tag (ta),
        .src_b_tag (tb)
    );

    rn_commit_map u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid   (ret_valid),
        .ret_dst     (rd),
        .ret_tag     (rt),
        .cmap_nxt    (cmap_nxt),
        .release_vec (release_vec),
        .refill_vec  (refill_vec)
    );
endmodule

// File: rtl/rn_map_chk.sv
// Module: property checker for the rename map, bound to the top.
// Watches the group ports and the pool state for allocation, stall and
// flush rules.
module rn_map_chk
    import rn_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic [GROUP_W-1:0]    rn_valid,
    input logic [GROUP_W-1:0]    rn_has_dst,
    input logic                  rn_stall,
    input logic [GROUP_W*TW-1:0] rn_dst_tag,
    input logic [GROUP_W-1:0]    ret_valid,
    input logic [PHYS_REGS-1:0]  free_q
);
    logic               acc;
    logic [GROUP_W-1:0] wants;
    logic               dup;

    // Observed acceptance and same-group tag collisions.
    always_comb begin : observe
        acc   = (|rn_valid) && !rn_stall && !flush;
        wants = rn_valid & rn_has_dst;
        dup   = 1'b0;
        for (int i = 0; i < GROUP_W; i++) begin
            for (int j = i + 1; j < GROUP_W; j++) begin
                if (wants[i] && wants[j] &&
                    rn_dst_tag[i*TW +: TW] == rn_dst_tag[j*TW +: TW]) dup = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < GROUP_W; i++) begin : g_slot_chk
        AST_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && wants[i]) |-> free_q[rn_dst_tag[i*TW +: TW]]); // R4
    end

    AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !dup); // R4

    AST_NODST_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wants == '0 && ret_valid == '0) |=> $stable(free_q)); // R4

    AST_STALL_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_stall && !flush && ret_valid == '0) |=> $stable(free_q)); // R5

    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_q) <= RENAME_SLOTS); // R7

    AST_FLUSH_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $countones(free_q) == RENAME_SLOTS); // R8
endmodule

bind rename_map rn_map_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .rn_valid   (rn_valid),
    .rn_has_dst (rn_has_dst),
    .rn_stall   (rn_stall),
    .rn_dst_tag (rn_dst_tag),
    .ret_valid  (ret_valid),
    .free_q     (free_q)
);

// File: tb/tb_rename_map.sv
// Bench: table of per-cycle stimulus and expected outputs, then directed tests.
module tb_rename_map;
    typedef struct packed {
        logic [3:0]  v;
        logic [3:0]  hd;
        logic [19:0] sa;
        logic [19:0] sb;
        logic [19:0] d;
        logic [3:0]  rv;
        logic [19:0] rd;
        logic [23:0] rt;
        logic        fl;
        logic        chk;
        logic        es;
        logic [23:0] ea;
        logic [23:0] eb;
        logic [23:0] ed;
    } vec_t;

    localparam int NV = 10;
    // Slot 3 is the leftmost field of each concatenation.
    localparam vec_t VECS [NV] = '{
        // V0: forwarding inside a group, slot 2 without destination
        '{4'b1111, 4'b1011, {5'd1,5'd2,5'd1,5'd2}, {5'd0,5'd1,5'd5,5'd3}, {5'd1,5'd0,5'd2,5'd1},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          {6'd32,6'd33,6'd32,6'd2}, {6'd0,6'd32,6'd5,6'd3}, {6'd34,6'd0,6'd33,6'd32}},
        // V1: later slot wins for r1
        '{4'b0001, 4'b0001, {15'd0,5'd1}, {15'd0,5'd2}, {15'd0,5'd3},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          {18'd0,6'd34}, {18'd0,6'd33}, {18'd0,6'd35}},
        // V2: four destinations while two retire
        '{4'b1111, 4'b1111, 20'd0, 20'd0, {5'd7,5'd6,5'd5,5'd4},
          4'b0011, {10'd0,5'd2,5'd1}, {12'd0,6'd33,6'd32}, 1'b0, 1'b1, 1'b0,
          24'd0, 24'd0, {6'd39,6'd38,6'd37,6'd36}},
        // V3: released tags 1 and 2 come first
        '{4'b1111, 4'b1111, {15'd0,5'd1}, {15'd0,5'd4}, {5'd11,5'd10,5'd9,5'd8},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          {18'd0,6'd34}, {18'd0,6'd36}, {6'd41,6'd40,6'd2,6'd1}},
        // V4: four more while r1 and r3 retire
        '{4'b1111, 4'b1111, 20'd0, 20'd0, {5'd15,5'd14,5'd13,5'd12},
          4'b0011, {10'd0,5'd3,5'd1}, {12'd0,6'd35,6'd34}, 1'b0, 1'b1, 1'b0,
          24'd0, 24'd0, {6'd45,6'd44,6'd43,6'd42}},
        // V5: exactly the last four tags
        '{4'b1111, 4'b1111, 20'd0, 20'd0, {5'd19,5'd18,5'd17,5'd16},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          24'd0, 24'd0, {6'd47,6'd46,6'd32,6'd3}},
        // V6: empty pool stalls
        '{4'b0001, 4'b0001, 20'd0, 20'd0, {15'd0,5'd20},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b0, 1'b1, 24'd0, 24'd0, 24'd0},
        // V7: no destination passes with an empty pool
        '{4'b0001, 4'b0000, {15'd0,5'd16}, 20'd0, 20'd0,
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          {18'd0,6'd3}, 24'd0, 24'd0},
        // V8: flush with a group on the inputs
        '{4'b0001, 4'b0001, 20'd0, 20'd0, {15'd0,5'd20},
          4'b0000, 20'd0, 24'd0, 1'b1, 1'b0, 1'b1, 24'd0, 24'd0, 24'd0},
        // V9: after flush, committed map and rebuilt pool
        '{4'b1111, 4'b0111, {5'd4,5'd2,5'd4,5'd1}, {5'd5,5'd20,5'd8,5'd3}, {5'd0,5'd5,5'd4,5'd4},
          4'b0000, 20'd0, 24'd0, 1'b0, 1'b1, 1'b0,
          {6'd2,6'd33,6'd1,6'd34}, {6'd3,6'd20,6'd8,6'd35}, {6'd0,6'd3,6'd2,6'd1}}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rn_valid = '0, rn_has_dst = '0, ret_valid = '0;
    logic [19:0] rn_src_a = '0, rn_src_b = '0, rn_dst = '0, ret_dst = '0;
    logic [23:0] ret_tag = '0;
    logic        flush = 1'b0;
    logic        rn_stall;
    logic [23:0] rn_src_a_tag, rn_src_b_tag, rn_dst_tag;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rename_map dut (
        .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_has_dst(rn_has_dst),
        .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_dst(rn_dst),
        .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_tag(ret_tag), .flush(flush),
        .rn_stall(rn_stall), .rn_src_a_tag(rn_src_a_tag), .rn_src_b_tag(rn_src_b_tag),
        .rn_dst_tag(rn_dst_tag)
    );

    task automatic cmp(input logic [23:0] act, input logic [23:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Drive one cycle's inputs after a falling edge and check before the rising edge.
    task automatic step(input vec_t x, input string req);
        @(negedge clk);
        rn_valid = x.v; rn_has_dst = x.hd; rn_src_a = x.sa; rn_src_b = x.sb; rn_dst = x.d;
        ret_valid = x.rv; ret_dst = x.rd; ret_tag = x.rt; flush = x.fl;
        #1;
        cmp({23'd0, rn_stall}, {23'd0, x.es}, {req, " stall (R5)"});
        if (x.chk) begin
            cmp(rn_src_a_tag, x.ea, {req, " src_a tags"});
            cmp(rn_src_b_tag, x.eb, {req, " src_b tags"});
            cmp(rn_dst_tag,   x.ed, {req, " dst tags"});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rn_valid = '0; rn_has_dst = '0; ret_valid = '0; flush = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle();
        vec_t x;
        x = '0;
        step(x, "idle");
    endtask

    initial begin : watchdog
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        vec_t x;
        do_reset();
        // Table: R2 R3 R4 R6 R7 R8 across the sequence.
        for (int n = 0; n < NV; n++) step(VECS[n], $sformatf("R2 R3 R4 R6 R7 R8 vector %0d", n));

        // R1: identity maps and first rename tag after reset.
        do_reset();
        x = '0; x.v = 4'b0001; x.hd = 4'b0001; x.sa = 20'd31; x.sb = 20'd7; x.d = 20'd9;
        x.chk = 1'b1; x.ea = 24'd31; x.eb = 24'd7; x.ed = 24'd32;
        step(x, "R1 reset state");

        // R5: partial pool, whole group stalls and leaves no trace.
        do_reset();
        for (int g = 0; g < 3; g++) begin
            x = '0; x.v = 4'b1111; x.hd = 4'b1111;
            x.d = {5'(4*g+4), 5'(4*g+3), 5'(4*g+2), 5'(4*g+1)};
            x.chk = 1'b1;
            x.ed = {6'(35+4*g), 6'(34+4*g), 6'(33+4*g), 6'(32+4*g)};
            step(x, "R4 fill");
        end
        x = '0; x.v = 4'b0001; x.hd = 4'b0001; x.d = 20'd13; x.chk = 1'b1; x.ed = 24'd44;
        step(x, "R4 fill single");
        x = '0; x.v = 4'b1111; x.hd = 4'b1111; x.d = {5'd23,5'd22,5'd21,5'd20}; x.es = 1'b1;
        step(x, "R5 short by one");
        x = '0; x.v = 4'b0001; x.sa = 20'd20; x.chk = 1'b1; x.ea = 24'd20;
        step(x, "R5 map untouched");
        x = '0; x.v = 4'b0001; x.hd = 4'b0001; x.d = 20'd20; x.chk = 1'b1; x.ed = 24'd45;
        step(x, "R5 pool untouched");

        // R7 R8: same-register retire pair in the flush cycle.
        do_reset();
        x = '0; x.v = 4'b0011; x.hd = 4'b0011; x.d = {10'd0,5'd6,5'd6}; x.chk = 1'b1;
        x.ed = {12'd0,6'd33,6'd32};
        step(x, "R4 twin dst");
        x = '0; x.rv = 4'b0011; x.rd = {10'd0,5'd6,5'd6}; x.rt = {12'd0,6'd33,6'd32}; x.fl = 1'b1;
        step(x, "R8 flush with retire");
        x = '0; x.v = 4'b0001; x.sa = 20'd6; x.chk = 1'b1; x.ea = 24'd33;
        step(x, "R7 chained commit");
        x = '0; x.v = 4'b1111; x.hd = 4'b1111; x.d = {5'd13,5'd12,5'd11,5'd10}; x.chk = 1'b1;
        x.ed = {6'd35,6'd34,6'd32,6'd6};
        step(x, "R7 R8 released tags");
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule